// File: doc/BRIEF.md
# JTAG Debug Port Access Register

This block is the data-register side of a debug port that sits behind a JTAG TAP. The TAP controller and instruction decode live elsewhere. They hand this block three inputs: one-cycle strobes for Capture-DR, Shift-DR and Update-DR, plus one select line for each of the two access instructions. One instruction reaches the debug-port registers and the other reaches a memory access port. Every access scan is 35 bits long. It carries a 3-bit request field and a 32-bit data word. On the way out, the same scan returns a 3-bit acknowledge and the result of the previous read.

Debug-port registers hold the identification word, a control/status word, a select word and a read buffer. The control/status word has sticky error and overrun flags and the power-up request/acknowledge bits. The select word picks an access-port number and a register bank. Access-port accesses go out on a valid/ready request channel. Only one access is outstanding at a time. Its response returns on a valid/ready channel. The response ready is high only while the block waits for that response, so a source must hold its response valid until it sees ready. The request valid is held, with its payload stable, until the memory side asserts ready.

Reads are pipelined. A read request never returns its own data. The data comes back in the data field of the next access scan, or through a read of the read-buffer register.

Top module: `dpacc_top`

## Requirements
- R1: A scan shifts least-significant bit first. Of the bits shifted in, bit 0 is read-not-write (1 = read), bits [2:1] are register address bits [3:2], and bits [34:3] are the write data. Of the bits shifted out, bits [2:0] are the acknowledge and bits [34:3] are the read buffer.
- R2: At Capture-DR the acknowledge is 3'b001 (WAIT) while an access-port transaction is outstanding, and 3'b010 (OK) otherwise.
- R3: A read places its result in the read buffer. The next access scan shifts that result out. A debug-port read at address 3 returns the read buffer and leaves it unchanged.
- R4: A debug-port write at address 2 stores an access-port number from bits [31:24] and a bank from bits [7:4]. Reading that address returns only those fields. An access-port request carries the address {port[7:0], bank[3:0], A[3:2]}.
- R5: An access-port write or read raises req_valid one cycle after Update-DR. req_write, req_addr and req_wdata stay stable until req_ready.
- R6: The response data of an access-port read is loaded into the read buffer.
- R7: A scan whose captured acknowledge was WAIT is discarded at Update-DR: no request is issued and no register changes. A retry after the outstanding access completes is accepted.
- R8: When overrun detection (control bit 0) is set, a discarded WAIT scan sets sticky overrun (control bit 1).
- R9: A response with rsp_err set raises sticky error (control bit 5). Writing 1 to bit 5 or bit 1 of the control word clears that flag.
- R10: Control bits 28 and 30 are the debug and system power-up requests and drive dbg_pwr_req and sys_pwr_req. Bits 29 and 31 read the dbg_pwr_ack and sys_pwr_ack inputs, so bits [31:28] read all ones once both domains are up.
- R11: While either sticky flag is set, access-port scans return OK but issue no request.
- R12: After reset no request is pending, both power requests are low, and the control word, select word and read buffer are zero.
- R13: A debug-port read at address 0 returns the ID_VALUE parameter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock |
| rst_n | input | 1 | Active-low reset |
| ir_dpacc | input | 1 | Debug-port access instruction selected |
| ir_apacc | input | 1 | Access-port access instruction selected |
| capture_dr | input | 1 | Capture-DR strobe |
| shift_dr | input | 1 | Shift-DR strobe |
| update_dr | input | 1 | Update-DR strobe |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out |
| dbg_pwr_req | output | 1 | Debug power-up request |
| dbg_pwr_ack | input | 1 | Debug power-up acknowledge |
| sys_pwr_req | output | 1 | System power-up request |
| sys_pwr_ack | input | 1 | System power-up acknowledge |
| req_valid | output | 1 | Access-port request valid |
| req_ready | input | 1 | Access-port request ready |
| req_write | output | 1 | Request is a write |
| req_addr | output | 14 | Port number, bank and word address |
| req_wdata | output | 32 | Write data |
| rsp_valid | input | 1 | Response valid |
| rsp_ready | output | 1 | Response ready (transaction outstanding) |
| rsp_rdata | input | 32 | Response read data |
| rsp_err | input | 1 | Response carries a fault |

## Verification
Some properties are checked on every cycle. The acknowledge bit shifted out after a capture must match whether a transaction is outstanding. A request may only start right after an Update-DR and must hold its payload while stalled. A response wait may only follow a request handshake. The power-request outputs may move only on an update. The bench scenarios show what needs a sequence of scans: read data arriving one scan late, a WAIT scan being discarded and then retried, the sticky flags being set and cleared with write-one-to-clear, and access-port traffic being blocked while a flag is set.

// File: rtl/dpacc_pkg.sv
package dpacc_pkg;
  localparam int DW     = 32;
  localparam int REQ_W  = 3;
  localparam int SCAN_W = DW + REQ_W;

  localparam logic [2:0] ACK_OK   = 3'b010;
  localparam logic [2:0] ACK_WAIT = 3'b001;

  // control word bit positions (software decodes these)
  localparam int B_ORUNDET = 0;
  localparam int B_STKORUN = 1;
  localparam int B_STKERR  = 5;
  localparam int B_DBGREQ  = 28;
  localparam int B_DBGACK  = 29;
  localparam int B_SYSREQ  = 30;
  localparam int B_SYSACK  = 31;

  typedef enum logic [1:0] {
    REG_ID    = 2'd0,
    REG_CTRL  = 2'd1,
    REG_SEL   = 2'd2,
    REG_RDBUF = 2'd3
  } dp_reg_e;

  typedef enum logic [1:0] {
    AP_IDLE  = 2'd0,
    AP_ISSUE = 2'd1,
    AP_AWAIT = 2'd2
  } ap_state_e;
endpackage

// File: rtl/dpacc_scan.sv
module dpacc_scan #(
  parameter int SW = 35
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cap,
  input  logic          sh,
  input  logic          tdi,
  input  logic [SW-1:0] cap_val,
  output logic          tdo,
  output logic [SW-1:0] sr_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   sr_q <= '0;
    else if (cap) sr_q <= cap_val;
    else if (sh)  sr_q <= {tdi, sr_q[SW-1:1]};
  end

  assign tdo = sr_q[0];
endmodule

// File: rtl/dpacc_ap.sv
module dpacc_ap
  import dpacc_pkg::*;
#(
  parameter int AW = 14
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic          wr,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic          req_valid,
  input  logic          req_ready,
  output logic          req_write,
  output logic [AW-1:0] req_addr,
  output logic [DW-1:0] req_wdata,
  input  logic          rsp_valid,
  output logic          rsp_ready,
  output logic          busy,
  output logic          done,
  output logic          done_rd
);
  ap_state_e st_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= AP_IDLE;
      req_write <= 1'b0;
      req_addr  <= '0;
      req_wdata <= '0;
    end else begin
      unique case (st_q)
        AP_IDLE: if (go) begin
          st_q      <= AP_ISSUE;
          req_write <= wr;
          req_addr  <= addr;
          req_wdata <= wdata;
        end
        AP_ISSUE: if (req_ready) st_q <= AP_AWAIT;
        AP_AWAIT: if (rsp_valid) st_q <= AP_IDLE;
        default:  st_q <= AP_IDLE;
      endcase
    end
  end

  assign req_valid = (st_q == AP_ISSUE);
  assign rsp_ready = (st_q == AP_AWAIT);
  assign busy      = (st_q != AP_IDLE);
  assign done      = rsp_ready && rsp_valid;
  assign done_rd   = done && !req_write;
endmodule

// File: rtl/dpacc_regs.sv
module dpacc_regs
  import dpacc_pkg::*;
#(
  parameter logic [31:0] ID_VALUE = 32'h0C0D_E001,
  parameter int          APSEL_W  = 8,
  parameter int          BANK_W   = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic               rd_en,
  input  dp_reg_e            reg_sel,
  input  logic [DW-1:0]      wdata,
  input  logic               wait_hit,
  input  logic               rsp_done,
  input  logic               rsp_done_rd,
  input  logic [DW-1:0]      rsp_rdata,
  input  logic               rsp_err,
  input  logic               dbg_ack,
  input  logic               sys_ack,
  output logic [DW-1:0]      rdbuf,
  output logic [APSEL_W-1:0] ap_sel,
  output logic [BANK_W-1:0]  bank,
  output logic               dbg_req,
  output logic               sys_req,
  output logic               sticky_any
);
  logic          orun_det, stk_orun, stk_err;
  logic [DW-1:0] ctrl_word, sel_word;

  always_comb begin
    ctrl_word            = '0;
    ctrl_word[B_ORUNDET] = orun_det;
    ctrl_word[B_STKORUN] = stk_orun;
    ctrl_word[B_STKERR]  = stk_err;
    ctrl_word[B_DBGREQ]  = dbg_req;
    ctrl_word[B_DBGACK]  = dbg_ack;
    ctrl_word[B_SYSREQ]  = sys_req;
    ctrl_word[B_SYSACK]  = sys_ack;
    sel_word                  = '0;
    sel_word[DW-1 -: APSEL_W] = ap_sel;
    sel_word[4 +: BANK_W]     = bank;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      orun_det <= 1'b0;
      stk_orun <= 1'b0;
      stk_err  <= 1'b0;
      dbg_req  <= 1'b0;
      sys_req  <= 1'b0;
      ap_sel   <= '0;
      bank     <= '0;
    end else begin
      if (wait_hit && orun_det) stk_orun <= 1'b1;
      if (rsp_done && rsp_err)  stk_err  <= 1'b1;
      if (wr_en) begin
        unique case (reg_sel)
          REG_CTRL: begin
            orun_det <= wdata[B_ORUNDET];
            dbg_req  <= wdata[B_DBGREQ];
            sys_req  <= wdata[B_SYSREQ];
            if (wdata[B_STKORUN]) stk_orun <= 1'b0;
            if (wdata[B_STKERR])  stk_err  <= 1'b0;
          end
          REG_SEL: begin
            ap_sel <= wdata[DW-1 -: APSEL_W];
            bank   <= wdata[4 +: BANK_W];
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdbuf <= '0;
    else if (rd_en) begin
      unique case (reg_sel)
        REG_ID:   rdbuf <= ID_VALUE;
        REG_CTRL: rdbuf <= ctrl_word;
        REG_SEL:  rdbuf <= sel_word;
        default:  ;
      endcase
    end else if (rsp_done_rd) rdbuf <= rsp_rdata;
  end

  assign sticky_any = stk_orun | stk_err;
endmodule

// File: rtl/dpacc_top.sv
module dpacc_top
  import dpacc_pkg::*;
#(
  parameter logic [31:0] ID_VALUE = 32'h0C0D_E001,
  parameter int          APSEL_W  = 8,
  parameter int          BANK_W   = 4,
  localparam int         AW       = APSEL_W + BANK_W + 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ir_dpacc,
  input  logic          ir_apacc,
  input  logic          capture_dr,
  input  logic          shift_dr,
  input  logic          update_dr,
  input  logic          tdi,
  output logic          tdo,
  output logic          dbg_pwr_req,
  input  logic          dbg_pwr_ack,
  output logic          sys_pwr_req,
  input  logic          sys_pwr_ack,
  output logic          req_valid,
  input  logic          req_ready,
  output logic          req_write,
  output logic [AW-1:0] req_addr,
  output logic [31:0]   req_wdata,
  input  logic          rsp_valid,
  output logic          rsp_ready,
  input  logic [31:0]   rsp_rdata,
  input  logic          rsp_err
);
  logic              acc_sel, cap_en, sh_en, upd_en;
  logic              ap_busy, ap_done, ap_done_rd, ack_ok_q;
  logic              accept, wait_hit, dp_wr, dp_rd, ap_go, sticky_any;
  logic [SCAN_W-1:0] sr_q, cap_val;
  logic [DW-1:0]     rdbuf;
  logic [APSEL_W-1:0] ap_sel;
  logic [BANK_W-1:0] bank;
  logic [1:0]        a_q;
  logic              rnw_q;

  assign acc_sel = ir_dpacc | ir_apacc;
  assign cap_en  = capture_dr & acc_sel;
  assign sh_en   = shift_dr & acc_sel;
  assign upd_en  = update_dr & acc_sel;
  assign cap_val = {rdbuf, ap_busy ? ACK_WAIT : ACK_OK};

  // the acknowledge captured in a scan decides that scan's fate
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ack_ok_q <= 1'b0;
    else if (cap_en) ack_ok_q <= !ap_busy;
  end

  assign rnw_q    = sr_q[0];
  assign a_q      = sr_q[2:1];
  assign accept   = upd_en & ack_ok_q;
  assign wait_hit = upd_en & !ack_ok_q;
  assign dp_wr    = accept & ir_dpacc & !rnw_q;
  assign dp_rd    = accept & ir_dpacc & rnw_q;
  assign ap_go    = accept & !ir_dpacc & ir_apacc & !sticky_any;

  dpacc_scan #(.SW(SCAN_W)) u_scan (
    .clk(clk), .rst_n(rst_n), .cap(cap_en), .sh(sh_en), .tdi(tdi),
    .cap_val(cap_val), .tdo(tdo), .sr_q(sr_q)
  );

  dpacc_regs #(.ID_VALUE(ID_VALUE), .APSEL_W(APSEL_W), .BANK_W(BANK_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(dp_wr), .rd_en(dp_rd),
    .reg_sel(dp_reg_e'(a_q)), .wdata(sr_q[SCAN_W-1:REQ_W]),
    .wait_hit(wait_hit), .rsp_done(ap_done), .rsp_done_rd(ap_done_rd),
    .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
    .dbg_ack(dbg_pwr_ack), .sys_ack(sys_pwr_ack),
    .rdbuf(rdbuf), .ap_sel(ap_sel), .bank(bank),
    .dbg_req(dbg_pwr_req), .sys_req(sys_pwr_req), .sticky_any(sticky_any)
  );

  dpacc_ap #(.AW(AW)) u_ap (
    .clk(clk), .rst_n(rst_n), .go(ap_go), .wr(!rnw_q),
    .addr({ap_sel, bank, a_q}), .wdata(sr_q[SCAN_W-1:REQ_W]),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .busy(ap_busy), .done(ap_done), .done_rd(ap_done_rd)
  );
endmodule

// File: rtl/dpacc_chk.sv
module dpacc_chk #(
  parameter int AW = 14
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ir_dpacc,
  input logic          ir_apacc,
  input logic          capture_dr,
  input logic          update_dr,
  input logic          tdo,
  input logic          dbg_pwr_req,
  input logic          sys_pwr_req,
  input logic          req_valid,
  input logic          req_ready,
  input logic          req_write,
  input logic [AW-1:0] req_addr,
  input logic [31:0]   req_wdata,
  input logic          rsp_ready
);
  // R2
  wait_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    capture_dr && (ir_dpacc || ir_apacc) && (req_valid || rsp_ready) |=> tdo);

  // R2
  ok_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    capture_dr && (ir_dpacc || ir_apacc) && !req_valid && !rsp_ready |=> !tdo);

  // R5
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_addr)
      && $stable(req_wdata) && $stable(req_write));

  // R7
  req_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_valid) |-> $past(update_dr));

  // R6
  rsp_after_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rsp_ready) |-> $past(req_valid && req_ready));

  // R10
  pwr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !update_dr |=> $stable(dbg_pwr_req) && $stable(sys_pwr_req));
endmodule

bind dpacc_top dpacc_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .ir_dpacc(ir_dpacc), .ir_apacc(ir_apacc),
  .capture_dr(capture_dr), .update_dr(update_dr), .tdo(tdo),
  .dbg_pwr_req(dbg_pwr_req), .sys_pwr_req(sys_pwr_req),
  .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
  .req_addr(req_addr), .req_wdata(req_wdata), .rsp_ready(rsp_ready)
);

// File: tb/sim_dpacc_top.sv
module sim_dpacc_top;
  localparam logic [31:0] ID = 32'h0C0D_E001;
  localparam logic [2:0]  OK = 3'b010, WT = 3'b001;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ir_dpacc = 0, ir_apacc = 0, capture_dr = 0, shift_dr = 0, update_dr = 0, tdi = 0;
  logic dbg_pwr_ack = 0, sys_pwr_ack = 0;
  logic req_ready = 0, rsp_valid = 0, rsp_err = 0;
  logic [31:0] rsp_rdata = '0;
  logic tdo, dbg_pwr_req, sys_pwr_req, req_valid, req_write, rsp_ready;
  logic [13:0] req_addr;
  logic [31:0] req_wdata;

  int checks = 0, errors = 0, n_req = 0, lat = 2;
  logic err_next = 0;
  logic        cap_write;
  logic [13:0] cap_addr;
  logic [31:0] cap_data;
  logic [31:0] mem [64];
  logic [2:0]  ack;
  logic [31:0] rd;

  always #4 clk = ~clk;

  dpacc_top #(.ID_VALUE(ID)) u0 (
    .clk(clk), .rst_n(rst_n), .ir_dpacc(ir_dpacc), .ir_apacc(ir_apacc),
    .capture_dr(capture_dr), .shift_dr(shift_dr), .update_dr(update_dr),
    .tdi(tdi), .tdo(tdo), .dbg_pwr_req(dbg_pwr_req), .dbg_pwr_ack(dbg_pwr_ack),
    .sys_pwr_req(sys_pwr_req), .sys_pwr_ack(sys_pwr_ack),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err)
  );

  // memory-side model with a programmable latency
  initial begin
    for (int i = 0; i < 64; i++) mem[i] = 32'h0;
    forever begin
      @(negedge clk);
      if (req_valid) begin
        repeat (lat) @(negedge clk);
        req_ready = 1; cap_write = req_write; cap_addr = req_addr; cap_data = req_wdata;
        n_req++;
        @(negedge clk);
        req_ready = 0;
        if (cap_write) mem[cap_addr[5:0]] = cap_data;
        repeat (lat) @(negedge clk);
        rsp_valid = 1; rsp_rdata = mem[cap_addr[5:0]]; rsp_err = err_next;
        @(negedge clk);
        rsp_valid = 0; rsp_err = 0;
      end
    end
  end

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // one full access scan: capture, 35 shifts, update (R1 bit order)
  task automatic scan(input bit ap, input bit [1:0] a, input bit rnw,
                      input logic [31:0] wd, output logic [2:0] ak, output logic [31:0] dout);
    logic [34:0] din, sout;
    din = {wd, a, rnw};
    ir_apacc = ap; ir_dpacc = !ap;
    @(negedge clk); capture_dr = 1;
    @(negedge clk); capture_dr = 0;
    for (int i = 0; i < 35; i++) begin
      shift_dr = 1; tdi = din[i]; sout[i] = tdo;
      @(negedge clk);
    end
    shift_dr = 0; update_dr = 1;
    @(negedge clk); update_dr = 0;
    ak = sout[2:0]; dout = sout[34:3];
  endtask

  task automatic wait_idle();
    while (req_valid || rsp_ready) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic dp_read(input bit [1:0] a, output logic [31:0] v);
    logic [2:0] k;
    logic [31:0] d;
    scan(0, a, 1, '0, k, d);
    scan(0, 2'd3, 1, '0, k, v);
  endtask

  task automatic t_reset();
    check("R12 req_valid", {31'b0, req_valid}, 0);
    check("R12 pwr reqs", {30'b0, dbg_pwr_req, sys_pwr_req}, 0);
    scan(0, 2'd1, 1, '0, ack, rd);
    check("R2 ack ok idle", {29'b0, ack}, {29'b0, OK});
    check("R12 rdbuf reset", rd, 0);
    scan(0, 2'd3, 1, '0, ack, rd);
    check("R12 ctrl reset", rd, 0);
    dp_read(2'd2, rd);
    check("R12 select reset", rd, 0);
  endtask

  task automatic t_idcode();
    dp_read(2'd0, rd);
    check("R13 id value", rd, ID);
    scan(0, 2'd3, 1, '0, ack, rd);
    check("R3 rdbuf unchanged", rd, ID);
  endtask

  task automatic t_power();
    scan(0, 2'd1, 0, 32'h5000_0000, ack, rd);
    check("R10 dbg req", {31'b0, dbg_pwr_req}, 1);
    check("R10 sys req", {31'b0, sys_pwr_req}, 1);
    dp_read(2'd1, rd);
    check("R10 acks low", rd, 32'h5000_0000);
    dbg_pwr_ack = 1; sys_pwr_ack = 1;
    dp_read(2'd1, rd);
    check("R10 all up", rd, 32'hF000_0000);
  endtask

  task automatic t_ap_write();
    lat = 3;
    scan(0, 2'd2, 0, 32'h0512_34A0, ack, rd);
    dp_read(2'd2, rd);
    check("R4 select fields", rd, 32'h0500_00A0);
    scan(1, 2'd1, 0, 32'hCAFE_0001, ack, rd);
    check("R2 ap write ack", {29'b0, ack}, {29'b0, OK});
    wait_idle();
    check("R4 R1 req addr", {18'b0, cap_addr}, {18'b0, 8'h05, 4'hA, 2'b01});
    check("R5 req write", {31'b0, cap_write}, 1);
    check("R5 req data", cap_data, 32'hCAFE_0001);
  endtask

  task automatic t_ap_read();
    scan(1, 2'd1, 1, '0, ack, rd);
    wait_idle();
    check("R5 read kind", {31'b0, cap_write}, 0);
    scan(0, 2'd3, 1, '0, ack, rd);
    check("R6 R3 read data", rd, 32'hCAFE_0001);
  endtask

  task automatic t_wait();
    int n0;
    lat = 15; n0 = n_req;
    scan(1, 2'd2, 0, 32'h1111_2222, ack, rd);
    scan(1, 2'd2, 0, 32'h3333_4444, ack, rd);
    check("R2 wait ack", {29'b0, ack}, {29'b0, WT});
    wait_idle();
    check("R7 one request", n_req, n0 + 1);
    check("R7 first kept", mem[6'h2A], 32'h1111_2222);
    scan(1, 2'd2, 0, 32'h3333_4444, ack, rd);
    check("R7 retry ack", {29'b0, ack}, {29'b0, OK});
    wait_idle();
    check("R7 retry done", mem[6'h2A], 32'h3333_4444);
    dp_read(2'd1, rd);
    check("R8 no detect no flag", rd, 32'hF000_0000);
  endtask

  task automatic t_overrun();
    int n0;
    scan(0, 2'd1, 0, 32'h5000_0001, ack, rd);
    scan(1, 2'd2, 0, 32'h0000_0055, ack, rd);
    scan(1, 2'd2, 0, 32'h0000_0066, ack, rd);
    wait_idle();
    dp_read(2'd1, rd);
    check("R8 overrun set", rd, 32'hF000_0003);
    n0 = n_req;
    scan(1, 2'd2, 0, 32'h0000_0077, ack, rd);
    check("R11 ack ok", {29'b0, ack}, {29'b0, OK});
    repeat (10) @(negedge clk);
    check("R11 no request", n_req, n0);
    check("R11 mem kept", mem[6'h2A], 32'h0000_0055);
    scan(0, 2'd1, 0, 32'h5000_0003, ack, rd);
    dp_read(2'd1, rd);
    check("R9 overrun cleared", rd, 32'hF000_0001);
    scan(1, 2'd2, 0, 32'h0000_0077, ack, rd);
    wait_idle();
    check("R11 released", mem[6'h2A], 32'h0000_0077);
  endtask

  task automatic t_err();
    int n0;
    lat = 2; err_next = 1;
    scan(1, 2'd1, 1, '0, ack, rd);
    wait_idle();
    err_next = 0;
    dp_read(2'd1, rd);
    check("R9 error set", rd, 32'hF000_0021);
    n0 = n_req;
    scan(1, 2'd1, 0, 32'hDEAD_0000, ack, rd);
    repeat (10) @(negedge clk);
    check("R11 blocked on error", n_req, n0);
    scan(0, 2'd1, 0, 32'h5000_0021, ack, rd);
    dp_read(2'd1, rd);
    check("R9 error cleared", rd, 32'hF000_0001);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_idcode();
    t_power();
    t_ap_write();
    t_ap_read();
    t_wait();
    t_overrun();
    t_err();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule